// File: doc/BRIEF.md
# Audio Decoder Mode Routing Controller

This block is the source-selection brain of a broadcast multichannel audio decoder. Three detector flags (stereo pilot present, second-program carrier present, second-program noise high) and a set of user control bits come in. The block decides what the noise-reduction stage is fed with (the difference signal, the second-program signal, or nothing). It also picks the source coded onto the decoder's left and right outputs and whether the second-program output is soft muted. Finally it sets the final TV left, right and auxiliary outputs to the decoder, one of two external stereo inputs, or mute.

Every selection is given as a 4-bit source code. The audio switches in the analog or DSP datapath decode these codes. All outputs are registered, so a glitch on a detector flag never reaches a switch between clock edges. The selection has three layers. The output mute overrides everything on the TV outputs. The TV/external choice comes next. The decoding mode, set by the second-program request, forced-mono and forced-second-program bits, comes last.

Source codes: MUTE=0, L=1, R=2, L+R=3, L-R=4, SAP (second program)=5, AUX1_L=6, AUX1_R=7, AUX2_L=8, AUX2_R=9.

Top module: `audio_route_ctrl`

## Requirements
- R1: While `rst_n` is low, every source output holds code 0 (MUTE) and `sap_soft_mute` is 0.
- R2: All outputs are registered: an input change sampled at one rising edge appears on the outputs right after that edge and never earlier.
- R3: With `out_on`=0, `tv_left`, `tv_right` and `tv_aux` are MUTE (0) whatever the other inputs are; the decoder outputs are unaffected.
- R4: With `out_on`=1 and `use_ext`=0, `tv_left`/`tv_right` equal `dec_left`/`dec_right`.
- R5: With `out_on`=1 and `use_ext`=1, `ext_port`=0 gives AUX1_L/AUX1_R (6/7) and `ext_port`=1 gives AUX2_L/AUX2_R (8/9).
- R6: `aux1_mono`=1 makes both TV outputs AUX1_L (6) when port 1 is selected, and `aux2_mono`=1 makes both AUX2_L (8) when port 2 is selected; each bit has no effect while the other port is selected.
- R7: With the second program not active and `force_mono`=0, stereo (`det_stereo`=1 or `force_stereo`=1) gives left L (1), right R (2), noise-reduction source L-R (4).
- R8: With the second program not active, `force_mono`=0 and no stereo, both decoder outputs are L+R (3) and the noise-reduction source is MUTE (0).
- R9: With `sap_req`=1 and `sap_always`=0, the second program is active only when `det_sap`=1; otherwise the outputs are as for `sap_req`=0.
- R10: With `sap_req`=1 and `sap_always`=1, the second program is active regardless of `det_sap`; with `force_mono`=0 the noise-reduction source, left and right are all SAP (5).
- R11: With `force_mono`=1, left is L+R (3); right is SAP (5) and the noise-reduction source SAP when the second program is active, otherwise right is L+R and the noise-reduction source MUTE.
- R12: `sap_soft_mute` is 1 exactly when the second program is active and either `det_noise`=1, or `sap_always`=1 with `det_sap`=0.
- R13: `tv_aux` is L+R (3) when `aux_sap`=0 and SAP (5) when `aux_sap`=1, subject to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_stereo | input | 1 | Stereo pilot detected |
| det_sap | input | 1 | Second-program carrier detected |
| det_noise | input | 1 | Second-program noise high |
| sap_req | input | 1 | Request second-program output |
| force_mono | input | 1 | Forced mono decoding |
| sap_always | input | 1 | Second program chosen even without detection |
| force_stereo | input | 1 | Treat input as stereo |
| out_on | input | 1 | 0 mutes the TV outputs |
| use_ext | input | 1 | 1 routes an external input to the TV outputs |
| ext_port | input | 1 | External port choice (0 = port 1, 1 = port 2) |
| aux1_mono | input | 1 | Port 1 left drives both sides |
| aux2_mono | input | 1 | Port 2 left drives both sides |
| aux_sap | input | 1 | Auxiliary TV output carries SAP instead of L+R |
| nr_src | output | 4 | Noise-reduction input source code |
| dec_left | output | 4 | Decoder left source code |
| dec_right | output | 4 | Decoder right source code |
| sap_soft_mute | output | 1 | Soft-mute request for the second-program output |
| tv_left | output | 4 | TV left source code |
| tv_right | output | 4 | TV right source code |
| tv_aux | output | 4 | Auxiliary TV output source code |

## Verification
The assertions take all flag and control inputs to be synchronous to `clk` and stable around the rising edge. They relate each output to the inputs sampled one edge earlier, and they stay disabled until one full cycle after reset has been released. The bench keeps within this rule: it changes inputs only on falling edges and reads outputs on the following falling edge. It walks every one of the 8192 input combinations and checks each result against its own truth function. It then pulses reset in mid-run to check the return to mute.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

  localparam int SRC_W   = 4;
  localparam int N_OUTS  = 6;
  localparam int BUS_W   = N_OUTS * SRC_W + 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_MUTE   = 4'd0,
    SRC_L      = 4'd1,
    SRC_R      = 4'd2,
    SRC_LPR    = 4'd3,
    SRC_LMR    = 4'd4,
    SRC_SAP    = 4'd5,
    SRC_AUX1_L = 4'd6,
    SRC_AUX1_R = 4'd7,
    SRC_AUX2_L = 4'd8,
    SRC_AUX2_R = 4'd9
  } src_e;

  // Second program is routed when requested, and either detected or forced.
  function automatic logic sap_route_on(input logic req, input logic always_on,
                                         input logic detected);
    return req & (always_on | detected);
  endfunction

  // Soft mute of the second-program output: noisy carrier, or forced with no carrier.
  function automatic logic sap_soft(input logic active, input logic noise,
                                    input logic always_on, input logic detected);
    return active & (noise | (always_on & ~detected));
  endfunction

  // External port pair: left of the port, right either the port right or its left.
  function automatic src_e aux_left(input logic port2);
    return port2 ? SRC_AUX2_L : SRC_AUX1_L;
  endfunction

  function automatic src_e aux_right(input logic port2, input logic mono1,
                                     input logic mono2);
    logic mono;
    mono = port2 ? mono2 : mono1;
    if (port2) return mono ? SRC_AUX2_L : SRC_AUX2_R;
    return mono ? SRC_AUX1_L : SRC_AUX1_R;
  endfunction

endpackage

// File: rtl/route_decode.sv
module route_decode
  import audio_route_pkg::*;
(
  input  logic det_stereo,
  input  logic det_sap,
  input  logic det_noise,
  input  logic sap_req,
  input  logic force_mono,
  input  logic sap_always,
  input  logic force_stereo,
  output src_e nr_src,
  output src_e dec_left,
  output src_e dec_right,
  output logic soft_mute,
  output logic sap_active,
  output logic stereo_ok
);

  assign sap_active = sap_route_on(sap_req, sap_always, det_sap);
  assign stereo_ok  = det_stereo | force_stereo;
  assign soft_mute  = sap_soft(sap_active, det_noise, sap_always, det_sap);

  always_comb begin
    nr_src    = SRC_MUTE;
    dec_left  = SRC_LPR;
    dec_right = SRC_LPR;
    if (force_mono) begin
      if (sap_active) begin
        nr_src    = SRC_SAP;
        dec_right = SRC_SAP;
      end
    end else if (sap_active) begin
      nr_src    = SRC_SAP;
      dec_left  = SRC_SAP;
      dec_right = SRC_SAP;
    end else if (stereo_ok) begin
      nr_src    = SRC_LMR;
      dec_left  = SRC_L;
      dec_right = SRC_R;
    end
  end

endmodule

// File: rtl/route_tvswitch.sv
module route_tvswitch
  import audio_route_pkg::*;
(
  input  logic out_on,
  input  logic use_ext,
  input  logic ext_port,
  input  logic aux1_mono,
  input  logic aux2_mono,
  input  logic aux_sap,
  input  src_e dec_left,
  input  src_e dec_right,
  output src_e tv_left,
  output src_e tv_right,
  output src_e tv_aux
);

  src_e ext_l, ext_r;

  assign ext_l = aux_left(ext_port);
  assign ext_r = aux_right(ext_port, aux1_mono, aux2_mono);

  always_comb begin
    if (!out_on) begin
      tv_left  = SRC_MUTE;
      tv_right = SRC_MUTE;
      tv_aux   = SRC_MUTE;
    end else begin
      tv_aux   = aux_sap ? SRC_SAP : SRC_LPR;
      tv_left  = use_ext ? ext_l : dec_left;
      tv_right = use_ext ? ext_r : dec_right;
    end
  end

endmodule

// File: rtl/route_pipe.sv
module route_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/audio_route_ctrl.sv
module audio_route_ctrl
  import audio_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_stereo,
  input  logic             det_sap,
  input  logic             det_noise,
  input  logic             sap_req,
  input  logic             force_mono,
  input  logic             sap_always,
  input  logic             force_stereo,
  input  logic             out_on,
  input  logic             use_ext,
  input  logic             ext_port,
  input  logic             aux1_mono,
  input  logic             aux2_mono,
  input  logic             aux_sap,
  output logic [SRC_W-1:0] nr_src,
  output logic [SRC_W-1:0] dec_left,
  output logic [SRC_W-1:0] dec_right,
  output logic             sap_soft_mute,
  output logic [SRC_W-1:0] tv_left,
  output logic [SRC_W-1:0] tv_right,
  output logic [SRC_W-1:0] tv_aux
);

  src_e       nr_c, dl_c, dr_c, tl_c, tr_c, ta_c;
  logic       soft_c;
  logic       sap_active_c;
  logic       stereo_ok_c;
  logic [BUS_W-1:0] bus_d, bus_q;

  route_decode u_decode (
    .det_stereo   (det_stereo),
    .det_sap      (det_sap),
    .det_noise    (det_noise),
    .sap_req      (sap_req),
    .force_mono   (force_mono),
    .sap_always   (sap_always),
    .force_stereo (force_stereo),
    .nr_src       (nr_c),
    .dec_left     (dl_c),
    .dec_right    (dr_c),
    .soft_mute    (soft_c),
    .sap_active   (sap_active_c),
    .stereo_ok    (stereo_ok_c)
  );

  route_tvswitch u_tvsw (
    .out_on    (out_on),
    .use_ext   (use_ext),
    .ext_port  (ext_port),
    .aux1_mono (aux1_mono),
    .aux2_mono (aux2_mono),
    .aux_sap   (aux_sap),
    .dec_left  (dl_c),
    .dec_right (dr_c),
    .tv_left   (tl_c),
    .tv_right  (tr_c),
    .tv_aux    (ta_c)
  );

  // Flags that only feed assertions and waveform views; folded into nothing.
  logic dbg_sap_active, dbg_stereo_ok;
  assign dbg_sap_active = sap_active_c;
  assign dbg_stereo_ok  = stereo_ok_c;

  assign bus_d = {nr_c, dl_c, dr_c, soft_c, tl_c, tr_c, ta_c};

  route_pipe #(.W(BUS_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_d),
    .q     (bus_q)
  );

  assign {nr_src, dec_left, dec_right, sap_soft_mute, tv_left, tv_right, tv_aux} = bus_q;

endmodule

// File: rtl/route_ctrl_checker.sv
module route_ctrl_checker
  import audio_route_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             out_on,
  input logic             use_ext,
  input logic             sap_req,
  input logic             sap_always,
  input logic             force_mono,
  input logic [SRC_W-1:0] nr_src,
  input logic [SRC_W-1:0] dec_left,
  input logic [SRC_W-1:0] dec_right,
  input logic             sap_soft_mute,
  input logic [SRC_W-1:0] tv_left,
  input logic [SRC_W-1:0] tv_right,
  input logic [SRC_W-1:0] tv_aux
);

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (nr_src == SRC_MUTE && tv_aux == SRC_MUTE && !sap_soft_mute); // R1
    end
  end

  AST_MUTE_WINS: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    !$past(out_on) |-> (tv_left == SRC_MUTE && tv_right == SRC_MUTE && tv_aux == SRC_MUTE)); // R3

  AST_TV_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(out_on) && !$past(use_ext)) |-> (tv_left == dec_left && tv_right == dec_right)); // R4

  AST_FORCED_SAP: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(sap_req) && $past(sap_always) && !$past(force_mono))
      |-> (nr_src == SRC_SAP && dec_left == SRC_SAP && dec_right == SRC_SAP)); // R10

  AST_MONO_LEFT: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(force_mono) |-> dec_left == SRC_LPR); // R11

  AST_SOFT_ONLY_SAP: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    sap_soft_mute |-> nr_src == SRC_SAP); // R12

  AST_DIFF_IS_STEREO: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (nr_src == SRC_LMR) |-> (dec_left == SRC_L && dec_right == SRC_R)); // R7

endmodule

bind audio_route_ctrl route_ctrl_checker u_route_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_on        (out_on),
  .use_ext       (use_ext),
  .sap_req       (sap_req),
  .sap_always    (sap_always),
  .force_mono    (force_mono),
  .nr_src        (nr_src),
  .dec_left      (dec_left),
  .dec_right     (dec_right),
  .sap_soft_mute (sap_soft_mute),
  .tv_left       (tv_left),
  .tv_right      (tv_right),
  .tv_aux        (tv_aux)
);

// File: tb/audio_route_ctrl_bench.sv
module audio_route_ctrl_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  N_DIR = 14;

  // vector: {stereo,sap,noise | sap_req,fmono,always,fst | on,ext,port,m1,m2,auxsap | nr,dl,dr,soft,tl,tr,ta}
  localparam logic [37:0] DIR [N_DIR] = '{
    {3'b100, 4'b0000, 6'b100000, 4'd4, 4'd1, 4'd2, 1'b0, 4'd1, 4'd2, 4'd3}, // R7
    {3'b000, 4'b0000, 6'b100000, 4'd0, 4'd3, 4'd3, 1'b0, 4'd3, 4'd3, 4'd3}, // R8
    {3'b000, 4'b0001, 6'b100000, 4'd4, 4'd1, 4'd2, 1'b0, 4'd1, 4'd2, 4'd3}, // R7
    {3'b110, 4'b1000, 6'b100000, 4'd5, 4'd5, 4'd5, 1'b0, 4'd5, 4'd5, 4'd3}, // R9
    {3'b100, 4'b1000, 6'b100000, 4'd4, 4'd1, 4'd2, 1'b0, 4'd1, 4'd2, 4'd3}, // R9
    {3'b000, 4'b1010, 6'b100000, 4'd5, 4'd5, 4'd5, 1'b1, 4'd5, 4'd5, 4'd3}, // R10
    {3'b110, 4'b1100, 6'b100000, 4'd5, 4'd3, 4'd5, 1'b0, 4'd3, 4'd5, 4'd3}, // R11
    {3'b100, 4'b0100, 6'b100000, 4'd0, 4'd3, 4'd3, 1'b0, 4'd3, 4'd3, 4'd3}, // R11
    {3'b111, 4'b1000, 6'b100000, 4'd5, 4'd5, 4'd5, 1'b1, 4'd5, 4'd5, 4'd3}, // R12
    {3'b100, 4'b0000, 6'b011111, 4'd4, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 4'd0}, // R3
    {3'b100, 4'b0000, 6'b110001, 4'd4, 4'd1, 4'd2, 1'b0, 4'd6, 4'd7, 4'd5}, // R5 R13
    {3'b100, 4'b0000, 6'b110100, 4'd4, 4'd1, 4'd2, 1'b0, 4'd6, 4'd6, 4'd3}, // R6
    {3'b100, 4'b0000, 6'b111100, 4'd4, 4'd1, 4'd2, 1'b0, 4'd8, 4'd9, 4'd3}, // R6
    {3'b100, 4'b0000, 6'b111010, 4'd4, 4'd1, 4'd2, 1'b0, 4'd8, 4'd8, 4'd3}  // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_stereo, det_sap, det_noise, sap_req, force_mono, sap_always, force_stereo;
  logic out_on, use_ext, ext_port, aux1_mono, aux2_mono, aux_sap;
  logic [3:0] nr_src, dec_left, dec_right, tv_left, tv_right, tv_aux;
  logic sap_soft_mute;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_route_ctrl u_audio_route_ctrl (
    .clk (clk), .rst_n (rst_n),
    .det_stereo (det_stereo), .det_sap (det_sap), .det_noise (det_noise),
    .sap_req (sap_req), .force_mono (force_mono), .sap_always (sap_always),
    .force_stereo (force_stereo), .out_on (out_on), .use_ext (use_ext),
    .ext_port (ext_port), .aux1_mono (aux1_mono), .aux2_mono (aux2_mono),
    .aux_sap (aux_sap), .nr_src (nr_src), .dec_left (dec_left),
    .dec_right (dec_right), .sap_soft_mute (sap_soft_mute),
    .tv_left (tv_left), .tv_right (tv_right), .tv_aux (tv_aux)
  );

  task automatic drive(input logic [12:0] v);
    {det_stereo, det_sap, det_noise, sap_req, force_mono, sap_always, force_stereo,
     out_on, use_ext, ext_port, aux1_mono, aux2_mono, aux_sap} = v;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent truth function: decide the mode first, then look up sources.
  function automatic logic [24:0] model(input logic [12:0] v);
    logic st, sp, nz, rq, fm, al, fs, on, ex, pt, m1, m2, ax;
    logic sap_mode;
    logic [3:0] nr, dl, dr, tl, tr, ta;
    logic sm;
    {st, sp, nz, rq, fm, al, fs, on, ex, pt, m1, m2, ax} = v;
    sap_mode = 1'b0;
    if (rq && al) sap_mode = 1'b1;
    if (rq && sp) sap_mode = 1'b1;
    case ({fm, sap_mode})
      2'b11:   begin nr = 5; dl = 3; dr = 5; end
      2'b10:   begin nr = 0; dl = 3; dr = 3; end
      2'b01:   begin nr = 5; dl = 5; dr = 5; end
      default: if (st || fs) begin nr = 4; dl = 1; dr = 2; end
               else begin nr = 0; dl = 3; dr = 3; end
    endcase
    sm = 1'b0;
    if (sap_mode && nz) sm = 1'b1;
    if (sap_mode && al && !sp) sm = 1'b1;
    ta = ax ? 4'd5 : 4'd3;
    if (!ex) begin tl = dl; tr = dr; end
    else if (!pt) begin tl = 6; tr = m1 ? 4'd6 : 4'd7; end
    else begin tl = 8; tr = m2 ? 4'd8 : 4'd9; end
    if (!on) begin tl = 0; tr = 0; ta = 0; end
    return {nr, dl, dr, sm, tl, tr, ta};
  endfunction

  task automatic compare(input logic [24:0] e, input string pre);
    chk({pre, " R9 nr_src"},        nr_src,        e[24:21]);
    chk({pre, " R11 dec_left"},     dec_left,      e[20:17]);
    chk({pre, " R10 dec_right"},    dec_right,     e[16:13]);
    chk({pre, " R12 soft_mute"},    sap_soft_mute, e[12]);
    chk({pre, " R4 tv_left"},       tv_left,       e[11:8]);
    chk({pre, " R6 tv_right"},      tv_right,      e[7:4]);
    chk({pre, " R13 tv_aux"},       tv_aux,        e[3:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    drive(13'b100_1010_111111);
    repeat (3) @(negedge clk);
    // R1: reset state with busy inputs
    chk("R1 nr_src reset", nr_src, 0);
    chk("R1 tv_left reset", tv_left, 0);
    chk("R1 tv_aux reset", tv_aux, 0);
    chk("R1 soft reset", sap_soft_mute, 0);
    rst_n = 1'b1;

    // Directed table walk
    for (int i = 0; i < N_DIR; i++) begin
      @(negedge clk);
      drive(DIR[i][37:25]);
      @(negedge clk);
      compare(DIR[i][24:0], $sformatf("dir%0d", i));
    end

    // R2: latency, no change before the edge
    @(negedge clk);
    drive(13'b100_0000_100000);
    @(negedge clk);
    drive(13'b100_0000_000000);
    #1;
    chk("R2 tv_left holds before edge", tv_left, 1);
    @(negedge clk);
    chk("R2 tv_left after edge", tv_left, 0);
    chk("R3 tv_aux muted", tv_aux, 0);

    // R5: port 2 stereo pair, mono bit of port 1 ignored
    drive(13'b000_0000_111100);
    @(negedge clk);
    chk("R5 port2 left", tv_left, 8);
    chk("R5 port2 right", tv_right, 9);

    // Exhaustive walk against the model
    for (int v = 0; v < 8192; v++) begin
      drive(v[12:0]);
      @(negedge clk);
      compare(model(v[12:0]), $sformatf("vec%0d", v));
    end

    // R1: reset in mid-run returns everything to mute
    drive(13'b111_1110_111111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 nr_src mid reset", nr_src, 0);
    chk("R1 dec_right mid reset", dec_right, 0);
    chk("R1 tv_right mid reset", tv_right, 0);
    chk("R1 soft mid reset", sap_soft_mute, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset dec_left", dec_left, 3);
    chk("R12 after reset soft", sap_soft_mute, 1);

    finish_run();
  end

endmodule